// File: doc/BRIEF.md
# Programmable Binary Cellular Logic Grid

This block is a two-dimensional array of one-bit cells that compute together. A shared program word selects one logic operation and a subset of the inputs each cell may see. On a step strobe every cell replaces its stored bit with the chosen function of its eight surrounding cells, its own bit and a per-cell external bit. The external bit normally carries the thresholded result of an earlier convolution stage. All cells read the values from before the step, so the order in which cells are evaluated has no effect on the result. A controller can change the program word between steps to run a sequence of binary image operations, such as growing, shrinking, edge marking or parity tests.

The same array can also be used as a small memory in which each row is one word. A row can be written in a single cycle, read back one cycle later, or filled serially by shifting bits into its first column. Serial filling means a loader only needs a row address and a single data bit.

Top module: `lgr_grid`

## Requirements
- R1: While reset is applied and right after it is released, every cell holds 0 and the read data output is 0.
- R2: On a step with opcode 0 (AND), each cell's new bit is the AND of its selected inputs. An empty selection mask gives 1.
- R3: On a step with opcode 1 (OR), each cell's new bit is the OR of its selected inputs. An empty selection mask gives 0.
- R4: On a step with opcode 2 (XOR), each cell's new bit is the parity of its selected inputs. An empty selection mask gives 0.
- R5: On a step with opcode 3 (INVERT), each cell's new bit is the complement of its own external bit, whatever the mask holds.
- R6: A step computes every cell from the values held before that step. Example: OR with only the west input selected moves a pattern exactly one column east per step.
- R7: A neighbour position that falls outside the grid reads as 0.
- R8: Mask bit positions: 0 north (row-1), 1 north-east, 2 east (column+1), 3 south-east, 4 south (row+1), 5 south-west, 6 west (column-1), 7 north-west, 8 the cell's own bit, 9 the external bit. Cell (r,c) sits at bit r*COLS+c of the flat state and external vectors, and row 0 is the top row.
- R9: A row write stores data bit c into column c of the addressed row, one cycle after the request, and leaves the other rows unchanged.
- R10: A row read presents the addressed row, as it was in the request cycle, on the read data output one cycle later. The output keeps that value until the next read.
- R11: A shift moves the shift bit into column 0 of the addressed row. Each other column c takes the old value of column c-1, and the old last column is dropped.
- R12: If a write, read or shift is requested in the same cycle as a step, the step is ignored. If a write and a shift are requested together, the write wins and the shift is ignored.
- R13: In a cycle with no step, write or shift, no cell changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| step_i | input | 1 | Request one synchronous update of all cells |
| prog_op_i | input | 2 | Opcode: 0 AND, 1 OR, 2 XOR, 3 INVERT |
| prog_mask_i | input | 10 | Input-select mask (bit positions as in R8) |
| ext_i | input | ROWS*COLS | Thresholded external bit for each cell |
| row_addr_i | input | AW | Row targeted by a write, read or shift |
| wr_en_i | input | 1 | Row write request |
| wr_data_i | input | COLS | Row write data |
| rd_en_i | input | 1 | Row read request |
| rd_data_o | output | COLS | Registered row read data |
| shift_en_i | input | 1 | Row shift-in request |
| shift_bit_i | input | 1 | Bit shifted into column 0 |
| state_o | output | ROWS*COLS | Stored bit of every cell |

## Verification
The checker assumes that the row address is always below ROWS whenever a write, read or shift is requested. It also assumes that the grid has at least two columns, so that a shifted row has a previous column to take from. The stimulus only uses addresses 0 to 3 on a four-row grid. It holds every request low during the synchronous reset release, so no write or shift property fires on a partially reset grid. The program word and external bits are held stable for the whole cycle in which a step is requested, and they are driven only on the falling clock edge.

// File: rtl/lgr_pkg.sv
package lgr_pkg;

  typedef enum logic [1:0] {
    LGR_AND = 2'd0,
    LGR_OR  = 2'd1,
    LGR_XOR = 2'd2,
    LGR_INV = 2'd3
  } lgr_op_e;

  localparam int unsigned LGR_NBR_W = 8;
  localparam int unsigned LGR_SEL_SELF = 8;
  localparam int unsigned LGR_SEL_EXT = 9;
  localparam int unsigned LGR_SEL_W = 10;

endpackage

// File: rtl/lgr_rst_sync.sv
module lgr_rst_sync (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) sync_q <= 2'b00;
    else              sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/lgr_cell.sv
module lgr_cell
  import lgr_pkg::*;
(
  input  logic [LGR_NBR_W-1:0] nbr_i,
  input  logic                 self_i,
  input  logic                 ext_i,
  input  lgr_op_e              op_i,
  input  logic [LGR_SEL_W-1:0] mask_i,
  output logic                 next_o
);

  logic [LGR_SEL_W-1:0] vec;
  logic [LGR_SEL_W-1:0] picked;

  always_comb begin
    vec    = {ext_i, self_i, nbr_i};
    picked = vec & mask_i;
    case (op_i)
      LGR_AND: next_o = &(vec | ~mask_i);
      LGR_OR:  next_o = |picked;
      LGR_XOR: next_o = ^picked;
      default: next_o = ~ext_i;
    endcase
  end

endmodule

// File: rtl/lgr_access_ctrl.sv
module lgr_access_ctrl #(
  parameter int ROWS = 4,
  parameter int AW   = 2
) (
  input  logic            step_i,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic            shift_en_i,
  input  logic [AW-1:0]   row_addr_i,
  output logic [ROWS-1:0] row_wr_o,
  output logic [ROWS-1:0] row_sh_o,
  output logic            step_go_o,
  output logic            cell_en_o
);

  logic access;

  assign access    = wr_en_i | rd_en_i | shift_en_i;
  assign step_go_o = step_i & ~access;
  assign cell_en_o = step_go_o | wr_en_i | shift_en_i;

  for (genvar r = 0; r < ROWS; r++) begin : g_row_dec
    logic hit;
    assign hit         = (row_addr_i == AW'(r));
    assign row_wr_o[r] = wr_en_i & hit;
    assign row_sh_o[r] = shift_en_i & ~wr_en_i & hit;
  end

endmodule

// File: rtl/lgr_row_read.sv
module lgr_row_read #(
  parameter int ROWS = 4,
  parameter int COLS = 8,
  parameter int AW   = 2,
  localparam int NC  = ROWS * COLS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en_i,
  input  logic [AW-1:0]   row_addr_i,
  input  logic [NC-1:0]   state_i,
  output logic [COLS-1:0] rd_data_o
);

  logic [COLS-1:0] rd_d;
  logic [COLS-1:0] rd_q;

  always_comb begin
    rd_d = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (row_addr_i == AW'(r)) rd_d = state_i[r*COLS +: COLS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;

endmodule

// File: rtl/lgr_grid.sv
module lgr_grid
  import lgr_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 8,
  localparam int AW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int NC  = ROWS * COLS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_i,
  input  logic [1:0]           prog_op_i,
  input  logic [LGR_SEL_W-1:0] prog_mask_i,
  input  logic [NC-1:0]        ext_i,
  input  logic [AW-1:0]        row_addr_i,
  input  logic                 wr_en_i,
  input  logic [COLS-1:0]      wr_data_i,
  input  logic                 rd_en_i,
  output logic [COLS-1:0]      rd_data_o,
  input  logic                 shift_en_i,
  input  logic                 shift_bit_i,
  output logic [NC-1:0]        state_o
);

  logic rst_sync_n;

  lgr_rst_sync u_rst (
    .clk        (clk),
    .rst_async_n(rst_n),
    .rst_sync_n (rst_sync_n)
  );

  logic [ROWS-1:0] row_wr;
  logic [ROWS-1:0] row_sh;
  logic            step_go;
  logic            cell_en;

  lgr_access_ctrl #(.ROWS(ROWS), .AW(AW)) u_ctrl (
    .step_i    (step_i),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .shift_en_i(shift_en_i),
    .row_addr_i(row_addr_i),
    .row_wr_o  (row_wr),
    .row_sh_o  (row_sh),
    .step_go_o (step_go),
    .cell_en_o (cell_en)
  );

  logic [NC-1:0] state_q;
  logic [NC-1:0] state_d;
  logic [ROWS+1:0][COLS+1:0] pad;
  lgr_op_e op;

  assign op = lgr_op_e'(prog_op_i);

  // zero ring around the stored grid
  always_comb begin
    pad = '0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        pad[r+1][c+1] = state_q[r*COLS+c];
      end
    end
  end

  for (genvar gr = 0; gr < ROWS; gr++) begin : g_r
    for (genvar gc = 0; gc < COLS; gc++) begin : g_c
      localparam int IDX = gr * COLS + gc;
      logic [LGR_NBR_W-1:0] nbr;
      logic                 nxt;
      logic                 shin;
      logic                 d_bit;

      // {NW, W, SW, S, SE, E, NE, N}
      assign nbr = {pad[gr][gc],   pad[gr+1][gc],   pad[gr+2][gc],
                    pad[gr+2][gc+1], pad[gr+2][gc+2], pad[gr+1][gc+2],
                    pad[gr][gc+2], pad[gr][gc+1]};

      lgr_cell u_cell (
        .nbr_i (nbr),
        .self_i(state_q[IDX]),
        .ext_i (ext_i[IDX]),
        .op_i  (op),
        .mask_i(prog_mask_i),
        .next_o(nxt)
      );

      if (gc == 0) begin : g_head
        assign shin = shift_bit_i;
      end else begin : g_body
        assign shin = state_q[IDX-1];
      end

      always_comb begin
        if (row_wr[gr])      d_bit = wr_data_i[gc];
        else if (row_sh[gr]) d_bit = shin;
        else if (step_go)    d_bit = nxt;
        else                 d_bit = state_q[IDX];
      end

      assign state_d[IDX] = d_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  state_q <= '0;
    else if (cell_en) state_q <= state_d;
  end

  lgr_row_read #(.ROWS(ROWS), .COLS(COLS), .AW(AW)) u_read (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_en_i   (rd_en_i),
    .row_addr_i(row_addr_i),
    .state_i   (state_q),
    .rd_data_o (rd_data_o)
  );

  assign state_o = state_q;

endmodule

// File: rtl/lgr_grid_chk.sv
module lgr_grid_chk #(
  parameter int ROWS = 4,
  parameter int COLS = 8,
  parameter int AW   = 2,
  localparam int NC  = ROWS * COLS
) (
  input logic            clk,
  input logic            rst_n,
  input logic            step_i,
  input logic [1:0]      prog_op_i,
  input logic [NC-1:0]   ext_i,
  input logic [AW-1:0]   row_addr_i,
  input logic            wr_en_i,
  input logic [COLS-1:0] wr_data_i,
  input logic            rd_en_i,
  input logic [COLS-1:0] rd_data_o,
  input logic            shift_en_i,
  input logic            shift_bit_i,
  input logic [NC-1:0]   state_o
);

  logic [COLS-1:0] row_cur;
  logic            any_acc;

  assign row_cur = state_o[row_addr_i*COLS +: COLS];
  assign any_acc = wr_en_i | rd_en_i | shift_en_i;

  AST_ROW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> state_o[$past(row_addr_i)*COLS +: COLS] == $past(wr_data_i)); // R9

  AST_ROW_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en_i && !wr_en_i) |=>
      state_o[$past(row_addr_i)*COLS +: COLS] == {$past(row_cur[COLS-2:0]), $past(shift_bit_i)}); // R11

  AST_ROW_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_data_o == $past(row_cur)); // R10

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o)); // R10

  AST_STEP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && rd_en_i && !wr_en_i && !shift_en_i) |=> $stable(state_o)); // R12

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !any_acc) |=> $stable(state_o)); // R13

  AST_INVERT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !any_acc && prog_op_i == 2'd3) |=> state_o == ~$past(ext_i)); // R5

endmodule

bind lgr_grid lgr_grid_chk #(.ROWS(ROWS), .COLS(COLS), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .step_i     (step_i),
  .prog_op_i  (prog_op_i),
  .ext_i      (ext_i),
  .row_addr_i (row_addr_i),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .rd_en_i    (rd_en_i),
  .rd_data_o  (rd_data_o),
  .shift_en_i (shift_en_i),
  .shift_bit_i(shift_bit_i),
  .state_o    (state_o)
);

// File: tb/lgr_grid_tb_top.sv
`timescale 1ns/1ps
module lgr_grid_tb_top;

  localparam int ROWS = 4;
  localparam int COLS = 8;
  localparam int AW   = 2;
  localparam int NC   = ROWS * COLS;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            step = 1'b0;
  logic [1:0]      op = 2'd0;
  logic [9:0]      mask = 10'd0;
  logic [NC-1:0]   ext = '0;
  logic [AW-1:0]   addr = '0;
  logic            we = 1'b0;
  logic [COLS-1:0] wd = '0;
  logic            re = 1'b0;
  logic [COLS-1:0] rd;
  logic            se = 1'b0;
  logic            sb = 1'b0;
  logic [NC-1:0]   st;

  always #2 clk = ~clk;

  lgr_grid #(.ROWS(ROWS), .COLS(COLS)) dut_i (
    .clk(clk), .rst_n(rst_n), .step_i(step), .prog_op_i(op), .prog_mask_i(mask),
    .ext_i(ext), .row_addr_i(addr), .wr_en_i(we), .wr_data_i(wd), .rd_en_i(re),
    .rd_data_o(rd), .shift_en_i(se), .shift_bit_i(sb), .state_o(st)
  );

  typedef struct {
    logic [NC-1:0]   st;
    logic [COLS-1:0] rd;
    string           tag;
  } exp_t;

  exp_t          sbq[$];
  int            checks = 0;
  int            fails = 0;
  logic [NC-1:0]   m_grid = '0;
  logic [COLS-1:0] m_rd = '0;

  task automatic check_st(input string tag, input logic [NC-1:0] act, input logic [NC-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s state actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_rd(input string tag, input logic [COLS-1:0] act, input logic [COLS-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s read data actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic getb(input logic [NC-1:0] g, input int r, input int c);
    if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return 1'b0;
    return g[r*COLS+c];
  endfunction

  // reference model of one update, written from the requirements
  function automatic logic [NC-1:0] mstep(input logic [NC-1:0] g, input logic [1:0] o,
                                          input logic [9:0] mk, input logic [NC-1:0] ex);
    int dr [8] = '{-1, -1, 0, 1, 1, 1, 0, -1};
    int dc [8] = '{0, 1, 1, 1, 0, -1, -1, -1};
    logic [NC-1:0] n;
    n = '0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        logic [9:0] v;
        for (int k = 0; k < 8; k++) v[k] = getb(g, r + dr[k], c + dc[k]);
        v[8] = g[r*COLS+c];
        v[9] = ex[r*COLS+c];
        case (o)
          2'd0: n[r*COLS+c] = &(v | ~mk);
          2'd1: n[r*COLS+c] = |(v & mk);
          2'd2: n[r*COLS+c] = ^(v & mk);
          default: n[r*COLS+c] = ~ex[r*COLS+c];
        endcase
      end
    end
    return n;
  endfunction

  // driver: one cycle of stimulus plus its expected result
  task automatic cyc(input logic st_i, input logic [1:0] op_i, input logic [9:0] mk_i,
                     input logic [NC-1:0] ex_i, input logic [AW-1:0] ad_i, input logic we_i,
                     input logic [COLS-1:0] wd_i, input logic re_i, input logic se_i,
                     input logic sb_i, input string tag_i);
    exp_t e;
    @(negedge clk);
    step = st_i; op = op_i; mask = mk_i; ext = ex_i; addr = ad_i;
    we = we_i; wd = wd_i; re = re_i; se = se_i; sb = sb_i;
    if (re_i) m_rd = m_grid[int'(ad_i)*COLS +: COLS];
    if (we_i) m_grid[int'(ad_i)*COLS +: COLS] = wd_i;
    else if (se_i) m_grid[int'(ad_i)*COLS +: COLS] = {m_grid[int'(ad_i)*COLS +: COLS-1], sb_i};
    else if (st_i && !re_i) m_grid = mstep(m_grid, op_i, mk_i, ex_i);
    e.st = m_grid; e.rd = m_rd; e.tag = tag_i;
    sbq.push_back(e);
  endtask

  task automatic do_write(input int a, input logic [COLS-1:0] d, input string t);
    cyc(1'b0, 2'd0, 10'd0, '0, AW'(a), 1'b1, d, 1'b0, 1'b0, 1'b0, t);
  endtask
  task automatic do_read(input int a, input string t);
    cyc(1'b0, 2'd0, 10'd0, '0, AW'(a), 1'b0, '0, 1'b1, 1'b0, 1'b0, t);
  endtask
  task automatic do_shift(input int a, input logic b, input string t);
    cyc(1'b0, 2'd0, 10'd0, '0, AW'(a), 1'b0, '0, 1'b0, 1'b1, b, t);
  endtask
  task automatic do_step(input logic [1:0] o, input logic [9:0] mk, input logic [NC-1:0] ex, input string t);
    cyc(1'b1, o, mk, ex, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0, t);
  endtask
  task automatic do_idle(input string t);
    cyc(1'b0, 2'd0, 10'd0, '0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0, t);
  endtask

  // monitor: compare just after each rising edge
  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      check_st(e.tag, st, e.st);
      check_rd(e.tag, rd, e.rd);
    end
  end

  bit done = 1'b0;

  initial begin
    #80000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check_st("R1 in reset", st, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_st("R1 after release", st, '0);
    check_rd("R1 after release", rd, '0);

    do_write(0, 8'hA5, "R9 row0");
    do_write(1, 8'h3C, "R9 row1");
    do_write(2, 8'h81, "R9 row2");
    do_write(3, 8'h7E, "R9 row3");
    for (int a = 0; a < ROWS; a++) do_read(a, "R10 read row");
    do_idle("R13 idle, R10 read data held");

    do_shift(1, 1'b1, "R11 shift 1");
    do_shift(1, 1'b0, "R11 shift 0");
    do_shift(1, 1'b1, "R11 shift 1 again");
    do_read(1, "R11 R10 read shifted row");

    do_step(2'd3, 10'h3FF, 32'hF0F0_1234, "R5 invert, mask ignored");
    do_step(2'd1, 10'h040, '0, "R6 R7 OR west moves east once");
    do_step(2'd1, 10'h040, '0, "R6 OR west second step");
    do_step(2'd1, 10'h004, '0, "R7 OR east, last column fed 0");
    do_step(2'd0, 10'h300, 32'hFFFF_0000, "R2 AND self and ext");
    do_step(2'd0, 10'h000, 32'h1234_5678, "R2 AND empty mask");
    do_step(2'd2, 10'h111, '0, "R4 XOR north south self");
    do_write(0, 8'h5A, "R9 row0 new");
    do_write(2, 8'h18, "R9 row2 new");
    do_step(2'd1, 10'h080, '0, "R8 OR north-west");
    do_step(2'd1, 10'h008, '0, "R8 OR south-east");
    do_step(2'd1, 10'h002, '0, "R8 OR north-east");
    do_step(2'd1, 10'h020, '0, "R8 OR south-west");
    do_step(2'd2, 10'h000, 32'hFFFF_FFFF, "R4 XOR empty mask");
    do_write(1, 8'h24, "R9 seed row1");
    do_step(2'd1, 10'h0FF, '0, "R3 R8 OR all neighbours");
    do_step(2'd2, 10'h2FF, 32'h0F0F_0F0F, "R4 XOR neighbours and ext");
    do_step(2'd1, 10'h000, 32'hFFFF_FFFF, "R3 OR empty mask");

    do_write(3, 8'hC3, "R9 row3 seed");
    cyc(1'b1, 2'd3, 10'h0, 32'hFFFF_FFFF, AW'(2), 1'b1, 8'h99, 1'b0, 1'b1, 1'b1,
        "R12 write beats shift and step");
    cyc(1'b1, 2'd3, 10'h0, 32'h0000_0000, AW'(3), 1'b0, '0, 1'b1, 1'b0, 1'b0,
        "R12 read blocks step");
    cyc(1'b1, 2'd1, 10'h0FF, '0, AW'(0), 1'b0, '0, 1'b0, 1'b1, 1'b0,
        "R12 shift blocks step");
    do_idle("R13 idle hold");
    do_idle("R13 idle hold end");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule